// File: doc/BRIEF.md
# Byte-Serial AES-128 Cipher Engine

This block encrypts or decrypts single 128-bit blocks with a 128-bit key, one byte at a time, and works in electronic codebook fashion: every block is handled on its own. A controller pulses `start` with the direction on `mode_dec`. It then streams 32 bytes in over a valid/ready byte port, first the key and then the block, and collects 16 result bytes from a second valid/ready byte port. Only one block is in flight at a time. `busy` marks the whole span from an accepted start to the last result byte.

Inside, one byte-wide substitution unit and one byte-wide column mixer serve both directions. Row shifting is done by how bytes are addressed, not by a 128-bit permutation network. Round keys are produced in place in a single 16-byte key register. A decryption first winds that register forward to the last round key and then steps it backwards once per round. Each round takes 36 cycles: 4 for the key step, 16 for substitution and 16 for column mixing.

Back-pressure: an input byte moves only on a cycle with both `in_valid` and `in_ready` high, so the source may leave gaps. A result byte moves only when `out_valid` and `out_ready` are both high. While `out_ready` is low the block holds the current byte and keeps `out_valid` high.

Top module: `aes_byte_core`

## Requirements
- R1: With `mode_dec` low at start, the 16 result bytes are the AES-128 encryption of the loaded block under the loaded key.
- R2: With `mode_dec` high at start, the 16 result bytes are the AES-128 decryption of the loaded block under the loaded key.
- R3: After an accepted start, `in_ready` is high until exactly 32 bytes have been accepted. Bytes 0 to 15 are the key and bytes 16 to 31 are the block, each in the order the bytes are written in the usual hex form (byte 0 first). `in_ready` is low at all other times, and `in_valid` has no effect then.
- R4: Result bytes leave in the same byte order. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change on the next cycle.
- R5: A `start` pulse while `busy` is high is ignored, and the direction chosen at the accepted start holds for the whole block.
- R6: After reset `busy`, `in_ready` and `out_valid` are low. `busy` is high on the cycle after an accepted start and low on the cycle after the sixteenth result handshake.
- R7: For encryption, `out_valid` first rises 376 clock edges after the edge that accepts the 32nd input byte.
- R8: For decryption, `out_valid` first rises 416 clock edges after the edge that accepts the 32nd input byte. The extra 40 edges are the forward key wind-up.
- R9: Blocks run back to back with any mix of directions and keys give results that do not depend on earlier blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a block when idle |
| mode_dec | input | 1 | Direction sampled with start: 0 encrypt, 1 decrypt |
| busy | output | 1 | High from accepted start until last result byte leaves |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Core accepts an input byte |
| in_data | input | 8 | Key byte, then block byte |
| out_valid | output | 1 | Result byte available |
| out_ready | input | 1 | Sink takes the result byte |
| out_data | output | 8 | Result byte |

## Verification
The core is checked with the two published AES-128 example key/block pairs in both directions. Because those are pinned to known constants, they separate a core that is right from one that merely agrees with a wrong reference model. Random keys and blocks with alternating directions follow. They expose faults that only some byte values or row positions reach, such as the wrap in the shift addressing and the reduction step in the inverse mixer. They also show that the round-constant sequence restarts for every block. All-zero and all-ones inputs test the zero case of the field inversion and saturated carries in the key schedule. Random gaps on the input, stalls on the output and stray start pulses check the handshake and hold rules, and separate timing faults from data faults.

// File: rtl/aes_byte_pkg.sv
package aes_byte_pkg;
  localparam int NBYTES  = 16;
  localparam int NROUNDS = 10;
  localparam int IW      = $clog2(NBYTES);
  localparam int RW      = $clog2(NROUNDS);

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_PRE, S_WHITE, S_KEY, S_SUB, S_MIX, S_OUT
  } phase_t;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] xt_back(input logic [7:0] a);
    return a[0] ? ({1'b1, 7'(a[7:1] ^ 7'h0d)}) : {1'b0, a[7:1]};
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, p;
    r = 8'h00;
    p = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ p;
      p = xt(p);
    end
    return r;
  endfunction

  function automatic logic [7:0] ginv(input logic [7:0] x);
    logic [7:0] r, p;
    r = 8'h01;
    p = x;
    for (int k = 1; k < 8; k++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] aff_fwd(input logic [7:0] b);
    return b ^ rotl(b, 1) ^ rotl(b, 2) ^ rotl(b, 3) ^ rotl(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] aff_back(input logic [7:0] b);
    return rotl(b, 1) ^ rotl(b, 3) ^ rotl(b, 6) ^ 8'h05;
  endfunction
endpackage

// File: rtl/aes_sbox_shared.sv
module aes_sbox_shared
  import aes_byte_pkg::*;
(
  input  logic [7:0] x,
  input  logic       inv,
  output logic [7:0] y
);
  logic [7:0] pre, g;
  always_comb begin
    pre = inv ? aff_back(x) : x;
    g   = ginv(pre);
    y   = inv ? g : aff_fwd(g);
  end
endmodule

// File: rtl/aes_col_mix.sv
module aes_col_mix
  import aes_byte_pkg::*;
(
  input  logic [3:0][7:0] b,
  input  logic            inv,
  output logic [7:0]      y
);
  logic [7:0] u, v;
  logic [3:0][7:0] c;
  always_comb begin
    u = xt(xt(b[0] ^ b[2]));
    v = xt(xt(b[1] ^ b[3]));
    c = b;
    if (inv) begin
      c[0] = b[0] ^ u;
      c[1] = b[1] ^ v;
      c[2] = b[2] ^ u;
      c[3] = b[3] ^ v;
    end
    y = xt(c[0]) ^ xt(c[1]) ^ c[1] ^ c[2] ^ c[3];
  end
endmodule

// File: rtl/aes_key_unit.sv
module aes_key_unit
  import aes_byte_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   restart,
  input  logic                   wr_en,
  input  logic [IW-1:0]          wr_idx,
  input  logic [7:0]             wr_byte,
  input  logic                   step_en,
  input  logic                   step_inv,
  input  logic [1:0]             step_row,
  output logic [7:0]             s_req,
  input  logic [7:0]             s_res,
  output logic [NBYTES-1:0][7:0] rk
);
  logic [NBYTES-1:0][7:0] k;
  logic [7:0] rc, rc_use, rc_b;
  logic [7:0] n0, n1, n2, n3;
  logic [1:0] jn;

  assign rk = k;
  assign jn = step_row + 2'd1;

  always_comb begin
    if (!step_inv)
      s_req = (step_row == 2'd3) ? (k[12] ^ k[8]) : k[{2'b11, jn}];
    else
      s_req = (step_row == 2'd3) ? k[12] : (k[{2'b11, jn}] ^ k[{2'b10, jn}]);
    rc_use = step_inv ? xt_back(rc) : rc;
    rc_b   = (step_row == 2'd0) ? rc_use : 8'h00;
    if (!step_inv) begin
      n0 = k[{2'b00, step_row}] ^ s_res ^ rc_b;
      n1 = k[{2'b01, step_row}] ^ n0;
      n2 = k[{2'b10, step_row}] ^ n1;
      n3 = k[{2'b11, step_row}] ^ n2;
    end else begin
      n3 = k[{2'b11, step_row}] ^ k[{2'b10, step_row}];
      n2 = k[{2'b10, step_row}] ^ k[{2'b01, step_row}];
      n1 = k[{2'b01, step_row}] ^ k[{2'b00, step_row}];
      n0 = k[{2'b00, step_row}] ^ s_res ^ rc_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k  <= '0;
      rc <= 8'h01;
    end else begin
      if (restart) rc <= 8'h01;
      if (wr_en) k[wr_idx] <= wr_byte;
      if (step_en) begin
        k[{2'b00, step_row}] <= n0;
        k[{2'b01, step_row}] <= n1;
        k[{2'b10, step_row}] <= n2;
        k[{2'b11, step_row}] <= n3;
        if (step_row == 2'd3) rc <= step_inv ? xt_back(rc) : xt(rc);
      end
    end
  end

  // R3
  load_step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !step_en);
endmodule

// File: rtl/aes_byte_core.sv
module aes_byte_core
  import aes_byte_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mode_dec,
  output logic       busy,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data
);
  localparam int CW = IW + 1;
  localparam logic [CW-1:0] LOAD_LAST = CW'(2 * NBYTES - 1);
  localparam logic [IW-1:0] B_LAST    = IW'(NBYTES - 1);
  localparam logic [RW-1:0] RND_LAST  = RW'(NROUNDS - 1);

  phase_t ph;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rnd;
  logic dec_q;
  logic [NBYTES-1:0][7:0] st, tmp, rk;
  logic [IW-1:0] idx, sub_dst;
  logic stepping, last_rnd;
  logic [7:0] key_req, sb_in, sb_out, mx, mix_byte;
  logic [3:0][7:0] col_a, col_b;

  assign idx       = cnt[IW-1:0];
  assign stepping  = (ph == S_PRE) || (ph == S_KEY);
  assign last_rnd  = (rnd == RND_LAST);
  assign sub_dst   = {idx[3:2] + idx[1:0], idx[1:0]};
  assign sb_in     = stepping ? key_req : st[idx];
  assign busy      = (ph != S_IDLE);
  assign in_ready  = (ph == S_LOAD);
  assign out_valid = (ph == S_OUT);
  assign out_data  = st[idx];

  aes_key_unit key_u (
    .clk(clk), .rst_n(rst_n),
    .restart((ph == S_IDLE) && start),
    .wr_en((ph == S_LOAD) && in_valid && !cnt[IW]),
    .wr_idx(idx), .wr_byte(in_data),
    .step_en(stepping), .step_inv((ph == S_KEY) && dec_q),
    .step_row(cnt[1:0]), .s_req(key_req), .s_res(sb_out), .rk(rk)
  );

  aes_sbox_shared sbox_u (.x(sb_in), .inv(!stepping && dec_q), .y(sb_out));

  always_comb begin
    for (int q = 0; q < 4; q++)
      col_a[q] = st[{dec_q ? (idx[3:2] - 2'(q)) : (idx[3:2] + 2'(q)), 2'(q)}];
    for (int m = 0; m < 4; m++)
      col_b[m] = col_a[idx[1:0] + 2'(m)];
  end

  aes_col_mix mix_u (.b(col_b), .inv(dec_q), .y(mx));

  assign mix_byte = (last_rnd ? col_a[idx[1:0]] : mx) ^ (dec_q ? 8'h00 : rk[idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= S_IDLE; cnt <= '0; rnd <= '0; dec_q <= 1'b0; st <= '0; tmp <= '0;
    end else begin
      case (ph)
        S_IDLE: if (start) begin
          ph <= S_LOAD; dec_q <= mode_dec; cnt <= '0;
        end
        S_LOAD: if (in_valid) begin
          if (cnt[IW]) st[idx] <= in_data;
          cnt <= cnt + 1'b1;
          if (cnt == LOAD_LAST) begin
            ph <= dec_q ? S_PRE : S_WHITE; cnt <= '0; rnd <= '0;
          end
        end
        S_PRE: begin
          cnt <= cnt + 1'b1;
          if (cnt[1:0] == 2'd3) begin
            cnt <= '0; rnd <= rnd + 1'b1;
            if (last_rnd) begin ph <= S_WHITE; rnd <= '0; end
          end
        end
        S_WHITE: begin
          st[idx] <= st[idx] ^ rk[idx];
          cnt <= cnt + 1'b1;
          if (idx == B_LAST) begin ph <= S_KEY; cnt <= '0; end
        end
        S_KEY: begin
          cnt <= cnt + 1'b1;
          if (cnt[1:0] == 2'd3) begin ph <= S_SUB; cnt <= '0; end
        end
        S_SUB: begin
          st[idx] <= sb_out ^ (dec_q ? rk[sub_dst] : 8'h00);
          cnt <= cnt + 1'b1;
          if (idx == B_LAST) begin ph <= S_MIX; cnt <= '0; end
        end
        S_MIX: begin
          tmp[idx] <= mix_byte;
          cnt <= cnt + 1'b1;
          if (idx == B_LAST) begin
            st <= tmp;
            st[B_LAST] <= mix_byte;
            cnt <= '0;
            if (last_rnd) ph <= S_OUT;
            else begin rnd <= rnd + 1'b1; ph <= S_KEY; end
          end
        end
        S_OUT: if (out_ready) begin
          cnt <= cnt + 1'b1;
          if (idx == B_LAST) begin ph <= S_IDLE; cnt <= '0; end
        end
        default: ph <= S_IDLE;
      endcase
    end
  end

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R5
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dec_q));
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!in_ready && !out_valid));
  // R3
  load_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cnt == LOAD_LAST) |=> !in_ready);
endmodule

// File: tb/aes_byte_core_tb.sv
module aes_byte_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode_dec = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic busy, in_ready, out_valid;
  logic [7:0] out_data;
  int nchk = 0, nerr = 0;
  logic [7:0] sbt [256];
  logic [7:0] isbt [256];

  always #2 clk = ~clk;

  aes_byte_core dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_dec(mode_dec), .busy(busy),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rl(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0, p = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= p;
      p = {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [7:0] gb(input logic [127:0] v, input int i);
    return v[127 - 8 * i -: 8];
  endfunction

  function automatic logic [127:0] tsub(input logic [127:0] s, input bit inv);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[127 - 8 * i -: 8] = inv ? isbt[gb(s, i)] : sbt[gb(s, i)];
    return o;
  endfunction

  function automatic logic [127:0] tshift(input logic [127:0] s, input bit inv);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127 - 8 * (4 * c + r) -: 8] = gb(s, 4 * ((inv ? c - r + 4 : c + r) % 4) + r);
    return o;
  endfunction

  function automatic logic [127:0] tmix(input logic [127:0] s, input bit inv);
    logic [127:0] o;
    logic [7:0] m [4];
    logic [7:0] acc;
    if (inv) begin m[0] = 8'h0e; m[1] = 8'h0b; m[2] = 8'h0d; m[3] = 8'h09; end
    else     begin m[0] = 8'h02; m[1] = 8'h03; m[2] = 8'h01; m[3] = 8'h01; end
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        acc = 0;
        for (int k = 0; k < 4; k++) acc ^= gm(m[(k - r + 4) % 4], gb(s, 4 * c + k));
        o[127 - 8 * (4 * c + r) -: 8] = acc;
      end
    return o;
  endfunction

  function automatic logic [127:0] tkey(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] t, w0, w1, w2, w3;
    t = {sbt[gb(k, 13)] ^ rc, sbt[gb(k, 14)], sbt[gb(k, 15)], sbt[gb(k, 12)]};
    w0 = k[127:96] ^ t; w1 = k[95:64] ^ w0; w2 = k[63:32] ^ w1; w3 = k[31:0] ^ w2;
    return {w0, w1, w2, w3};
  endfunction

  function automatic logic [127:0] ref_aes(input logic [127:0] k, input logic [127:0] d,
                                           input bit dec);
    logic [127:0] rks [11];
    logic [127:0] s;
    logic [7:0] rc = 8'h01;
    rks[0] = k;
    for (int r = 1; r <= 10; r++) begin
      rks[r] = tkey(rks[r - 1], rc);
      rc = gm(rc, 8'h02);
    end
    if (!dec) begin
      s = d ^ rks[0];
      for (int r = 1; r <= 10; r++) begin
        s = tshift(tsub(s, 0), 0);
        if (r < 10) s = tmix(s, 0);
        s ^= rks[r];
      end
    end else begin
      s = d ^ rks[10];
      for (int r = 9; r >= 0; r--) begin
        s = tsub(tshift(s, 1), 1) ^ rks[r];
        if (r > 0) s = tmix(s, 1);
      end
    end
    return s;
  endfunction

  task automatic run_block(input logic [127:0] key, input logic [127:0] blk, input bit dec,
                           output logic [127:0] res);
    int n, lat, got;
    bit hold, ro, v;
    logic [7:0] hb, d;
    @(negedge clk);
    start = 1; mode_dec = dec;
    @(posedge clk); @(negedge clk);
    start = 0;
    chk(busy && in_ready, "R6 busy/in_ready after start", {busy, in_ready}, 2'b11);
    n = 0;
    while (n < 32) begin
      if ($urandom % 4 == 0) begin
        in_valid = 0; start = ($urandom % 2 == 0); mode_dec = ~dec;
      end else begin
        in_valid = 1; in_data = (n < 16) ? gb(key, n) : gb(blk, n - 16);
      end
      v = in_valid && in_ready;
      @(posedge clk); @(negedge clk);
      start = 0; mode_dec = dec; in_valid = 0;
      if (v) n++;
    end
    lat = 0;
    while (!out_valid && lat < 1000) begin
      in_valid = ($urandom % 5 == 0); in_data = 8'($urandom);
      start = ($urandom % 7 == 0); mode_dec = ~dec;
      @(posedge clk); lat++; @(negedge clk);
    end
    in_valid = 0; start = 0;
    if (dec) chk(lat == 416, "R8 decrypt latency", lat, 416);
    else     chk(lat == 376, "R7 encrypt latency", lat, 376);
    got = 0; hold = 0; res = '0;
    while (got < 16 && lat < 2000) begin
      ro = ($urandom % 3 != 0); out_ready = ro;
      start = ($urandom % 6 == 0);
      v = out_valid; d = out_data;
      if (hold) chk(v && d == hb, "R4 byte held under stall", {v, d}, {1'b1, hb});
      hold = v && !ro; hb = d;
      @(posedge clk); lat++;
      if (v && ro) begin res[127 - 8 * got -: 8] = d; got++; end
      @(negedge clk);
    end
    out_ready = 0; start = 0;
    chk(!busy && !out_valid, "R6 idle after last byte", {busy, out_valid}, 2'b00);
  endtask

  task automatic check_block(input logic [127:0] key, input logic [127:0] blk, input bit dec);
    logic [127:0] res, exp;
    exp = ref_aes(key, blk, dec);
    run_block(key, blk, dec, res);
    chk(res == exp, dec ? "R2 R9 decrypt result" : "R1 R9 encrypt result", res, exp);
  endtask

  initial begin
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ (p << 1) ^ (p[7] ? 8'h1b : 8'h00);
      q ^= q << 1; q ^= q << 2; q ^= q << 4;
      if (q[7]) q ^= 8'h09;
      x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
      sbt[p] = x ^ 8'h63;
    end while (p != 8'h01);
    sbt[0] = 8'h63;
    for (int i = 0; i < 256; i++) isbt[sbt[i]] = 8'(i);
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [127:0] k1, p1, c1, k2, p2, c2, rk, rp, rr;
    void'($urandom(32'h5eed_1234));
    k1 = 128'h000102030405060708090a0b0c0d0e0f;
    p1 = 128'h00112233445566778899aabbccddeeff;
    c1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    k2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    p2 = 128'h3243f6a8885a308d313198a2e0370734;
    c2 = 128'h3925841d02dc09fbdc118597196a0b32;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(!busy && !in_ready && !out_valid, "R6 reset state",
        {busy, in_ready, out_valid}, 3'b000);
    in_valid = 1; in_data = 8'hA5;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    chk(!in_ready && !busy, "R3 idle in_valid ignored", {in_ready, busy}, 2'b00);
    chk(ref_aes(k1, p1, 0) == c1, "R1 reference model vector", ref_aes(k1, p1, 0), c1);
    run_block(k1, p1, 0, rr); chk(rr == c1, "R1 known vector A encrypt", rr, c1);
    run_block(k1, c1, 1, rr); chk(rr == p1, "R2 known vector A decrypt", rr, p1);
    run_block(k2, p2, 0, rr); chk(rr == c2, "R1 known vector B encrypt", rr, c2);
    run_block(k2, c2, 1, rr); chk(rr == p2, "R2 known vector B decrypt", rr, p2);
    check_block('0, '0, 0);
    check_block('1, '1, 1);
    check_block('1, '0, 0);
    for (int t = 0; t < 6; t++) begin
      rk = {$urandom, $urandom, $urandom, $urandom};
      rp = {$urandom, $urandom, $urandom, $urandom};
      check_block(rk, rp, t[0]);
      run_block(rk, rp, 0, rr);
      run_block(rk, rr, 1, rr);
      chk(rr == rp, "R9 round trip", rr, rp);
    end
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule